// File: doc/BRIEF.md
# Multi-mode prescaled timer core

This block is a 32-bit timer with a power-of-two prescaler. Software configures it through a simple register port: a count register, a compare register, a shared hold register and a control word. Once enabled, the timer advances its count on each prescaled tick and acts according to the selected mode. It can run once and stop, run continuously, produce a two-phase PWM waveform, timestamp external or software events, or record the count at each compare match. It drives one output pin with selectable polarity and one interrupt line.

The hold register has two roles. In PWM mode it sets the count at which the waveform moves into its second phase, and the compare register ends that phase. In capture and compare modes it receives the count at the moment of each event. One sticky flag records matches and captures, and an enable bit gates that flag onto the interrupt line.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, every readable register reads 0, the pin is 0 and the interrupt is 0.
- R2: With prescale field n (ctrl bits 7:4, values above 12 act as 12), an enabled timer advances its count once every 2^n clocks. The first advance happens 2^n clocks after the edge that wrote the enable. The prescaler is held at zero while the timer is disabled.
- R3: In continuous mode (mode 1), a tick on which count equals compare reloads the count to 1, sets the flag and toggles the pin state. Any other tick increments the count.
- R4: One-shot mode (mode 0) behaves like mode 1 at a match, and also clears the enable bit, so the count then stays at 1.
- R5: In PWM mode (mode 3), a tick on which count equals the hold value drives the pin state to 1. A tick on which count equals compare reloads the count to 1, drives the pin state to 0 and sets the flag.
- R6: In compare mode (mode 5), every tick increments the count. A tick on which count equals compare also copies the count into the hold register, sets the flag and toggles the pin state.
- R7: In capture mode (mode 4), an event while enabled copies the count into hold, reloads the count to 1 and sets the flag. An event is a rising edge of the event input, or a falling edge when ctrl bit 11 is 1, or a write of 1 to ctrl bit 12. An event takes precedence over a tick in the same cycle.
- R8: Capture/compare mode (mode 7) captures events as in R7. A tick match on compare reloads the count to 1 without setting the flag.
- R9: The flag is status bit 0 and is cleared by writing 1 to it. A set in the same cycle wins over the clear. The interrupt equals the flag ANDed with ctrl bit 10.
- R10: The pin equals the internal pin state XOR ctrl bit 8.
- R11: A register write takes effect over any timer update in the same cycle. In modes 2, 6, 8, 14 and every other unlisted code, the count does not change.
- R12: Register addresses are: 0 count, 1 compare, 2 hold, 3 control, 4 status. Other addresses read 0. Control bits are: 3:0 mode, 7:4 prescale, 8 polarity, 9 enable, 10 interrupt enable, 11 falling-edge select and 12 software capture. Bit 12 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Read data, combinational from rdAddr |
| evIn | input | 1 | External capture event |
| timerOut | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler state would show as count advances that come too early or too late. The count register exposes this within one prescale period of enabling. A wrong mode decode or a wrong match comparison would show in the next readback of count or hold, and as a pin edge one tick off. A lost or spurious flag set would appear on the interrupt in the cycle after the event. The bench compares every port against a reference model on every cycle, so any divergence is caught in the cycle it happens.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [3:0] {
    MD_ONCE    = 4'd0,
    MD_LOOP    = 4'd1,
    MD_EVCOUNT = 4'd2,
    MD_PWM     = 4'd3,
    MD_CAPT    = 4'd4,
    MD_CMPR    = 4'd5,
    MD_GATE    = 4'd6,
    MD_CAPCMP  = 4'd7,
    MD_DUALCAP = 4'd8,
    MD_IGATE   = 4'd14
  } modeE;

  // control word layout
  localparam int CTRL_BITS = 12;
  localparam int MODE_LO   = 0;
  localparam int MODE_HI   = 3;
  localparam int PRE_LO    = 4;
  localparam int PRE_HI    = 7;
  localparam int POL_BIT   = 8;
  localparam int EN_BIT    = 9;
  localparam int IE_BIT    = 10;
  localparam int NEG_BIT   = 11;
  localparam int SWCAP_BIT = 12;

  // register addresses
  localparam logic [2:0] A_COUNT = 3'd0;
  localparam logic [2:0] A_CMP   = 3'd1;
  localparam logic [2:0] A_HOLD  = 3'd2;
  localparam logic [2:0] A_CTRL  = 3'd3;
  localparam logic [2:0] A_STAT  = 3'd4;

  typedef struct packed {
    logic inc;
    logic reload;
    logic capture;
    logic outSet;
    logic outClr;
    logic outToggle;
  } strobeT;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int MAX_SHIFT = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrCtrl,
  input  logic                 wrStat,
  input  logic [CTRL_BITS:0]   wrBits,
  input  logic                 evIn,
  input  logic                 cmpHit,
  input  logic                 pwmHit,
  output strobeT               stb,
  output logic [CTRL_BITS-1:0] ctrlQ,
  output logic                 flagQ,
  output logic                 irq
);

  localparam int PW = MAX_SHIFT;

  logic [PW-1:0] prescCnt;
  logic [PW-1:0] prescMask;
  logic [3:0]    shiftSel;
  logic          en;
  logic          tick;
  logic          evPrev;
  logic          edgeHit;
  logic          evHit;
  logic          setFlag;
  logic          clrEn;
  logic [3:0]    modeBits;

  assign en       = ctrlQ[EN_BIT];
  assign modeBits = ctrlQ[MODE_HI:MODE_LO];

  // prescaler: tick when the masked low bits are all ones
  always_comb begin
    shiftSel  = (ctrlQ[PRE_HI:PRE_LO] > 4'(MAX_SHIFT)) ? 4'(MAX_SHIFT)
                                                       : ctrlQ[PRE_HI:PRE_LO];
    prescMask = ~({PW{1'b1}} << shiftSel);
    tick      = en && ((prescCnt & prescMask) == prescMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !en || tick) prescCnt <= '0;
    else                      prescCnt <= prescCnt + 1'b1;
  end

  // event detection
  always_ff @(posedge clk) begin
    if (!rstN) evPrev <= 1'b0;
    else       evPrev <= evIn;
  end

  assign edgeHit = ctrlQ[NEG_BIT] ? (evPrev & ~evIn) : (~evPrev & evIn);
  assign evHit   = edgeHit | (wrCtrl & wrBits[SWCAP_BIT]);

  // mode decode into datapath strobes
  always_comb begin
    stb     = '0;
    setFlag = 1'b0;
    clrEn   = 1'b0;
    if (en) begin
      case (modeBits)
        MD_ONCE, MD_LOOP: begin
          if (tick) begin
            if (cmpHit) begin
              stb.reload    = 1'b1;
              stb.outToggle = 1'b1;
              setFlag       = 1'b1;
              clrEn         = (modeBits == MD_ONCE);
            end else begin
              stb.inc = 1'b1;
            end
          end
        end
        MD_PWM: begin
          if (tick) begin
            if (cmpHit) begin
              stb.reload = 1'b1;
              stb.outClr = 1'b1;
              setFlag    = 1'b1;
            end else begin
              stb.inc    = 1'b1;
              stb.outSet = pwmHit;
            end
          end
        end
        MD_CMPR: begin
          if (tick) begin
            stb.inc = 1'b1;
            if (cmpHit) begin
              stb.capture   = 1'b1;
              stb.outToggle = 1'b1;
              setFlag       = 1'b1;
            end
          end
        end
        MD_CAPT, MD_CAPCMP: begin
          if (evHit) begin
            stb.capture = 1'b1;
            stb.reload  = 1'b1;
            setFlag     = 1'b1;
          end else if (tick) begin
            if (cmpHit && modeBits == MD_CAPCMP) stb.reload = 1'b1;
            else                                 stb.inc    = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // control word and sticky flag
  always_ff @(posedge clk) begin
    if (!rstN)      ctrlQ <= '0;
    else if (wrCtrl) ctrlQ <= wrBits[CTRL_BITS-1:0];
    else if (clrEn)  ctrlQ[EN_BIT] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      flagQ <= 1'b0;
    else if (setFlag)               flagQ <= 1'b1;
    else if (wrStat && wrBits[0])   flagQ <= 1'b0;
  end

  assign irq = flagQ & ctrlQ[IE_BIT];

  AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> prescCnt == '0); // R2
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits == MD_ONCE && tick && cmpHit && !wrCtrl) |=> !en); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !(wrStat && wrBits[0])) |=> flagQ); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    setFlag |=> flagQ); // R9

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrCount,
  input  logic          wrCmp,
  input  logic          wrHold,
  input  logic [DW-1:0] wrData,
  input  strobeT        stb,
  input  logic          polarity,
  output logic          cmpHit,
  output logic          pwmHit,
  output logic [DW-1:0] countQ,
  output logic [DW-1:0] cmpQ,
  output logic [DW-1:0] holdQ,
  output logic          timerOut
);

  localparam logic [DW-1:0] RELOAD_VAL = DW'(1);

  logic outState;

  assign cmpHit = (countQ == cmpQ);
  assign pwmHit = (countQ == holdQ);

  always_ff @(posedge clk) begin
    if (!rstN)          countQ <= '0;
    else if (wrCount)   countQ <= wrData;
    else if (stb.reload) countQ <= RELOAD_VAL;
    else if (stb.inc)    countQ <= countQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)      cmpQ <= '0;
    else if (wrCmp) cmpQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            holdQ <= '0;
    else if (wrHold)      holdQ <= wrData;
    else if (stb.capture) holdQ <= countQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              outState <= 1'b0;
    else if (stb.outSet)    outState <= 1'b1;
    else if (stb.outClr)    outState <= 1'b0;
    else if (stb.outToggle) outState <= ~outState;
  end

  assign timerOut = outState ^ polarity;

  AST_ONE_MOTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.inc, stb.reload})); // R3
  AST_RELOAD_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.reload && !wrCount) |=> countQ == RELOAD_VAL); // R3
  AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && !wrHold) |=> holdQ == $past(countQ)); // R7
  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.outSet, stb.outClr, stb.outToggle})); // R5

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 3,
  parameter int MAX_SHIFT = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  input  logic          evIn,
  output logic          timerOut,
  output logic          irq
);

  strobeT               stb;
  logic [CTRL_BITS-1:0] ctrlQ;
  logic                 flagQ;
  logic                 cmpHit;
  logic                 pwmHit;
  logic [DW-1:0]        countQ;
  logic [DW-1:0]        cmpQ;
  logic [DW-1:0]        holdQ;
  logic                 wrCount, wrCmp, wrHold, wrCtrl, wrStat;

  assign wrCount = wrEn && (wrAddr == AW'(A_COUNT));
  assign wrCmp   = wrEn && (wrAddr == AW'(A_CMP));
  assign wrHold  = wrEn && (wrAddr == AW'(A_HOLD));
  assign wrCtrl  = wrEn && (wrAddr == AW'(A_CTRL));
  assign wrStat  = wrEn && (wrAddr == AW'(A_STAT));

  tmr_ctrl #(.MAX_SHIFT(MAX_SHIFT)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrCtrl (wrCtrl),
    .wrStat (wrStat),
    .wrBits (wrData[CTRL_BITS:0]),
    .evIn   (evIn),
    .cmpHit (cmpHit),
    .pwmHit (pwmHit),
    .stb    (stb),
    .ctrlQ  (ctrlQ),
    .flagQ  (flagQ),
    .irq    (irq)
  );

  tmr_datapath #(.DW(DW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrCount  (wrCount),
    .wrCmp    (wrCmp),
    .wrHold   (wrHold),
    .wrData   (wrData),
    .stb      (stb),
    .polarity (ctrlQ[POL_BIT]),
    .cmpHit   (cmpHit),
    .pwmHit   (pwmHit),
    .countQ   (countQ),
    .cmpQ     (cmpQ),
    .holdQ    (holdQ),
    .timerOut (timerOut)
  );

  always_comb begin
    case (rdAddr)
      AW'(A_COUNT): rdData = countQ;
      AW'(A_CMP):   rdData = cmpQ;
      AW'(A_HOLD):  rdData = holdQ;
      AW'(A_CTRL):  rdData = {{(DW-CTRL_BITS){1'b0}}, ctrlQ};
      AW'(A_STAT):  rdData = {{(DW-1){1'b0}}, flagQ};
      default:      rdData = '0;
    endcase
  end

endmodule

// File: tb/prescaled_timer_tb.sv
`timescale 1ns/1ps
module prescaled_timer_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [2:0]  wrAddr;
  logic [31:0] wrData;
  logic [2:0]  rdAddr;
  logic [31:0] rdData;
  logic        evIn;
  logic        timerOut;
  logic        irq;
  logic        runChk = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  prescaled_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evIn(evIn), .timerOut(timerOut), .irq(irq)
  );

  // reference model state
  logic [31:0] mCount, mCmp, mHold;
  logic [11:0] mCtrl, mPresc;
  logic        mFlag, mOut, mEvPrev;

  function automatic logic [31:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return mCount;
      3'd1: return mCmp;
      3'd2: return mHold;
      3'd3: return {20'b0, mCtrl};
      3'd4: return {31'b0, mFlag};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string modeReq(input logic [3:0] m);
    case (m)
      4'd0: return "R4";
      4'd1: return "R3";
      4'd3: return "R5";
      4'd4: return "R7";
      4'd5: return "R6";
      4'd7: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    logic en, tick, ev, ch, ph, wc, ws;
    logic inc, rel, cap, oSet, oClr, oTog, setF, clrE;
    logic [3:0] md, sh;
    logic [11:0] msk;
    logic [31:0] nCount, nHold;
    if (!rstN) begin
      mCount = 0; mCmp = 0; mHold = 0; mCtrl = 0; mPresc = 0;
      mFlag = 0; mOut = 0; mEvPrev = 0;
    end else begin
      en   = mCtrl[9];
      md   = mCtrl[3:0];
      sh   = (mCtrl[7:4] > 4'd12) ? 4'd12 : mCtrl[7:4];
      msk  = ~(12'hFFF << sh);
      tick = en && ((mPresc & msk) == msk);
      wc   = wrEn && wrAddr == 3'd3;
      ws   = wrEn && wrAddr == 3'd4;
      ev   = (mCtrl[11] ? (mEvPrev && !evIn) : (!mEvPrev && evIn)) || (wc && wrData[12]);
      ch   = (mCount == mCmp);
      ph   = (mCount == mHold);
      {inc, rel, cap, oSet, oClr, oTog, setF, clrE} = '0;
      if (en) begin
        if (md == 4'd0 || md == 4'd1) begin
          if (tick) begin
            if (ch) begin rel = 1; oTog = 1; setF = 1; clrE = (md == 4'd0); end
            else inc = 1;
          end
        end else if (md == 4'd3) begin
          if (tick) begin
            if (ch) begin rel = 1; oClr = 1; setF = 1; end
            else begin inc = 1; oSet = ph; end
          end
        end else if (md == 4'd5) begin
          if (tick) begin
            inc = 1;
            if (ch) begin cap = 1; oTog = 1; setF = 1; end
          end
        end else if (md == 4'd4 || md == 4'd7) begin
          if (ev) begin cap = 1; rel = 1; setF = 1; end
          else if (tick) begin
            if (ch && md == 4'd7) rel = 1; else inc = 1;
          end
        end
      end
      nHold  = (wrEn && wrAddr == 3'd2) ? wrData : cap ? mCount : mHold;
      nCount = (wrEn && wrAddr == 3'd0) ? wrData : rel ? 32'd1 : inc ? mCount + 1 : mCount;
      if (wrEn && wrAddr == 3'd1) mCmp = wrData;
      mPresc = (!en || tick) ? 12'd0 : mPresc + 1;
      mHold  = nHold;
      mCount = nCount;
      mFlag  = setF ? 1'b1 : (ws && wrData[0]) ? 1'b0 : mFlag;
      mCtrl  = wc ? wrData[11:0] : clrE ? (mCtrl & ~12'h200) : mCtrl;
      mOut   = oSet ? 1'b1 : oClr ? 1'b0 : oTog ? ~mOut : mOut;
      mEvPrev = evIn;
    end
  end

  // every-cycle comparison of all ports against the model
  always @(negedge clk) begin
    if (rstN && runChk) begin
      #2;
      check(modeReq(mCtrl[3:0]), {31'b0, timerOut}, {31'b0, mOut ^ mCtrl[8]});
      check("R9", {31'b0, irq}, {31'b0, mFlag & mCtrl[10]});
      check(modeReq(mCtrl[3:0]), rdData, mRead(rdAddr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rdAddr = a;
    #0.2;
    v = rdData;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin : stim
    logic [31:0] v;
    logic        p0;
    logic [31:0] lastCmp;
    void'($urandom(32'd1234));
    rstN = 0; wrEn = 0; wrAddr = 0; wrData = 0; rdAddr = 0; evIn = 0;
    repeat (4) @(negedge clk);
    rstN = 1; runChk = 1;

    // R1 / R12: reset state
    for (int a = 0; a < 4; a++) begin rd(3'(a), v); check("R1", v, 0); end
    @(negedge clk);
    rd(3'd4, v); check("R1", v, 0);
    rd(3'd5, v); check("R12", v, 0);
    check("R1", {31'b0, timerOut}, 0);
    check("R1", {31'b0, irq}, 0);

    // R2: prescale by 4, first advance four clocks after enable
    wr(3'd1, 100); wr(3'd0, 0); wr(3'd3, 32'h221);
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R2", v, 0);
    @(negedge clk);
    rd(3'd0, v); check("R2", v, 1);
    repeat (4) @(negedge clk);
    rd(3'd0, v); check("R2", v, 2);

    // R4: one-shot stops and clears enable
    wr(3'd3, 0); wr(3'd4, 1); wr(3'd1, 3); wr(3'd0, 0); wr(3'd3, 32'h200);
    repeat (8) @(negedge clk);
    rd(3'd0, v); check("R4", v, 1);
    rd(3'd3, v); check("R4", v, 0);
    rd(3'd4, v); check("R4", v, 1);

    // R9: interrupt gating, write-1-to-clear, set wins
    check("R9", {31'b0, irq}, 0);
    wr(3'd3, 32'h400);
    check("R9", {31'b0, irq}, 1);
    wr(3'd4, 1);
    check("R9", {31'b0, irq}, 0);
    wr(3'd3, 32'h604);
    @(negedge clk);
    wrEn = 1; wrAddr = 3'd4; wrData = 1; evIn = 1;
    @(negedge clk);
    wrEn = 0;
    rd(3'd4, v); check("R9", v, 1);

    // R7: capture on rising, falling and software events
    evIn = 0;
    wr(3'd4, 1); wr(3'd0, 0);
    repeat (5) @(negedge clk);
    rd(3'd0, v); check("R7", v, 5);
    evIn = 1;
    @(negedge clk);
    rd(3'd2, v); check("R7", v, 5);
    rd(3'd0, v); check("R7", v, 1);
    rd(3'd4, v); check("R7", v, 1);
    wr(3'd3, 32'hE04); wr(3'd0, 0);
    repeat (3) @(negedge clk);
    evIn = 0;
    @(negedge clk);
    rd(3'd2, v); check("R7", v, 3);
    rd(3'd0, v); check("R7", v, 1);
    wr(3'd0, 0);
    repeat (2) @(negedge clk);
    wr(3'd3, 32'h1E04);
    rd(3'd2, v); check("R7", v, 3);
    rd(3'd0, v); check("R7", v, 1);
    rd(3'd3, v); check("R12", v, 32'hE04);

    // R8: capture/compare reloads without flag
    wr(3'd3, 0); wr(3'd0, 0); wr(3'd1, 3); wr(3'd4, 1); wr(3'd3, 32'h207);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      rd(3'd0, v); check("R8", {31'b0, (v >= 1 && v <= 3)}, 1);
    end
    rd(3'd4, v); check("R8", v, 0);

    // R6: compare mode keeps counting, captures at match
    wr(3'd3, 0); wr(3'd0, 0); wr(3'd1, 3); wr(3'd4, 1); wr(3'd3, 32'h205);
    repeat (4) @(negedge clk);
    rd(3'd0, v); check("R6", v, 4);
    rd(3'd2, v); check("R6", v, 3);
    rd(3'd4, v); check("R6", v, 1);

    // R5: PWM two-phase waveform
    wr(3'd3, 0); wr(3'd0, 0); wr(3'd1, 4); wr(3'd2, 2); wr(3'd3, 32'h203);
    repeat (3) @(negedge clk);
    check("R5", {31'b0, timerOut}, 1);
    repeat (2) @(negedge clk);
    check("R5", {31'b0, timerOut}, 0);
    rd(3'd0, v); check("R5", v, 1);

    // R10: polarity inverts the pin
    wr(3'd3, 0);
    p0 = timerOut;
    wr(3'd3, 32'h100);
    check("R10", {31'b0, timerOut}, {31'b0, ~p0});
    wr(3'd3, 0);

    // R11: write wins; unsupported modes hold
    wr(3'd1, 1000); wr(3'd3, 32'h201); wr(3'd0, 500);
    rd(3'd0, v); check("R11", v, 500);
    wr(3'd3, 32'h202); wr(3'd0, 7);
    repeat (5) @(negedge clk);
    rd(3'd0, v); check("R11", v, 7);
    wr(3'd3, 32'h209);
    repeat (5) @(negedge clk);
    rd(3'd0, v); check("R11", v, 7);

    // R3: continuous mode wraps to 1 and toggles
    wr(3'd3, 0); wr(3'd0, 0); wr(3'd1, 2); wr(3'd4, 1);
    p0 = timerOut;
    wr(3'd3, 32'h201);
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R3", v, 1);
    rd(3'd4, v); check("R3", v, 1);
    check("R3", {31'b0, timerOut}, {31'b0, ~p0});
    repeat (2) @(negedge clk);
    rd(3'd0, v); check("R3", v, 1);
    check("R3", {31'b0, timerOut}, {31'b0, p0});

    // random phase, checked every cycle by the model
    lastCmp = 2;
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [3:0] md;
      @(negedge clk);
      wrEn = 0;
      r = $urandom % 100;
      if (r < 4) begin
        case ($urandom % 8)
          0: md = 0; 1: md = 1; 2: md = 3; 3: md = 4;
          4: md = 5; 5: md = 7; 6: md = 2; default: md = 9;
        endcase
        wrEn = 1; wrAddr = 3'd3;
        wrData = {19'b0, 1'($urandom % 8 == 0), 1'($urandom), 1'($urandom),
                  1'($urandom % 6 != 0), 1'($urandom), 4'($urandom % 3), md};
      end else if (r < 6) begin
        lastCmp = 2 + $urandom % 30;
        wrEn = 1; wrAddr = 3'd1; wrData = lastCmp;
      end else if (r < 8) begin
        wrEn = 1; wrAddr = 3'd2; wrData = 1 + $urandom % (lastCmp - 1);
      end else if (r < 9) begin
        wrEn = 1; wrAddr = 3'd0; wrData = $urandom % 10;
      end else if (r < 11) begin
        wrEn = 1; wrAddr = 3'd4; wrData = 1;
      end
      if ($urandom % 6 == 0) evIn = ~evIn;
      rdAddr = 3'($urandom % 8);
    end
    @(negedge clk);
    wrEn = 0;
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule